// File: doc/BRIEF.md
# Serial Slave Low-Power Entry and Wake Controller

This block is the command front end of a byte-organised serial memory (262,144 bytes, so an 18-bit byte address further down the chain). It works as a serial slave. It takes in the first byte of every chip-select frame, most significant bit first. It watches that byte for the power-down command 0xB9. When the command is seen, the block puts the device into a low-power state. While the device is in that state, the serial clock and data inputs have no effect and the data output stays released.

Every serial input passes through a synchronizer into a faster system clock domain, and all edges are detected there. The block enters the low-power state on the chip-select rising edge that closes a frame of exactly eight clocks carrying 0xB9. A chip-select falling edge during the low-power state starts wake-up. Wake-up is a lockout window counted in system clocks. Command decoding returns only when that window has finished. Any other opcode goes to a downstream decoder, together with a one-cycle strobe.

Top module: `spi_sleep_ctrl`

## Requirements
- R1: After reset, asleep_o=0, ready_o=1, viol_o=0, op_valid_o=0 and so_oe_o=0.
- R2: Opcode bits are taken on SCK rising edges, MSB first. The result is the same whether the clock idles low (mode 0) or high (mode 3).
- R3: When a frame's eighth bit completes any opcode other than 0xB9, op_valid_o pulses for exactly one cycle and op_o carries the byte. The power state does not change.
- R4: A frame of exactly eight clocks carrying 0xB9 sets asleep_o. It is set on the closing CS rising edge and not before that edge.
- R5: If a 0xB9 frame has one or more SCK rising edges after the eighth, the request is cancelled and the device stays awake.
- R6: A frame with fewer than eight clocks changes nothing. The bit count and shift register clear when CS rises, so the next frame decodes from bit zero.
- R7: While asleep, SCK and SI toggling with CS high have no effect. so_oe_o stays 0 and op_valid_o never pulses.
- R8: A CS falling edge while asleep clears asleep_o and starts a lockout of REC_CYCLES system clocks. During the lockout ready_o=0, clocked bits are ignored and so_oe_o=0. ready_o returns after the lockout.
- R9: CS may go high again during the lockout. The lockout still completes on time, and this raises no violation.
- R10: A second CS falling edge during the lockout sets viol_o. That frame is not decoded. viol_o stays set until reset.
- R11: so_oe_o is 1 only while awake and inside a frame that began while awake, with CS low. so_o then follows so_data_i. Otherwise so_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| si_i | input | 1 | Serial data in |
| so_data_i | input | 1 | Output bit from the downstream data path |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for the tri-state SO pad |
| op_o | output | OP_W | Last decoded non-sleep opcode |
| op_valid_o | output | 1 | One-cycle strobe for op_o |
| asleep_o | output | 1 | Low-power state active |
| ready_o | output | 1 | Command decoding enabled |
| viol_o | output | 1 | Sticky early-reselect violation |

## Verification
The bench sends all 256 opcodes, alternating between the two clock idle levels. A decoder that matched any byte other than 0xB9 would put the device to sleep at the wrong time. A shifter that sampled on the wrong edge or in the wrong bit order would report the wrong opcodes. The bench then sends 0xB9 with extra clocks, partial frames, and clocking while asleep; a design that acted at the eighth clock or kept stale bits across frames would fall asleep when it should not. The lockout is probed just before it ends and just after it ends, with early deselect and with an illegal reselect. A counter off by its length, or a violation flag that cleared itself, would show up as ready or viol having the wrong value.

// File: rtl/spi_sleep_pkg.sv
package spi_sleep_pkg;
  typedef enum logic [1:0] {
    PWR_AWAKE   = 2'd0,
    PWR_ASLEEP  = 2'd1,
    PWR_RECOVER = 2'd2
  } pwr_state_e;

  localparam logic [7:0] SLEEP_OPCODE = 8'hB9;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int N = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] lvl_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL[g];
        sync_q <= RST_VAL[g];
      end else begin
        meta_q <= d_i[g];
        sync_q <= meta_q;
      end
    end
    assign lvl_o[g] = sync_q;
  end
endmodule

// File: rtl/spi_op_shifter.sv
module spi_op_shifter
  import spi_sleep_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            cs_lvl_i,
  input  logic            cs_fall_i,
  input  logic            cs_rise_i,
  input  logic            sck_rise_i,
  input  logic            si_i,
  output logic            frame_ok_o,
  output logic [OP_W-1:0] op_o,
  output logic            op_valid_o,
  output logic            sleep_req_o
);
  localparam int CNT_W = $clog2(OP_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(OP_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(OP_W + 1);
  localparam logic [OP_W-1:0]  SLEEP_OP = OP_W'(SLEEP_OPCODE);

  logic [OP_W-1:0]  sr_q, op_q;
  logic [CNT_W-1:0] cnt_q;
  logic             frame_q, opv_q;
  logic [OP_W-1:0]  sr_nxt;
  logic             take_bit;

  assign sr_nxt   = {sr_q[OP_W-2:0], si_i};
  assign take_bit = frame_q && en_i && !cs_lvl_i && sck_rise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      cnt_q   <= '0;
      frame_q <= 1'b0;
    end else if (cs_rise_i) begin
      sr_q    <= '0;
      cnt_q   <= '0;
      frame_q <= 1'b0;
    end else if (cs_fall_i && en_i) begin
      sr_q    <= '0;
      cnt_q   <= '0;
      frame_q <= 1'b1;
    end else if (take_bit) begin
      if (cnt_q < CNT_FULL) sr_q <= sr_nxt;
      if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q  <= '0;
      opv_q <= 1'b0;
    end else begin
      opv_q <= 1'b0;
      if (take_bit && cnt_q == CNT_FULL - 1'b1 && sr_nxt != SLEEP_OP) begin
        op_q  <= sr_nxt;
        opv_q <= 1'b1;
      end
    end
  end

  assign frame_ok_o  = frame_q;
  assign op_o        = op_q;
  assign op_valid_o  = opv_q;
  // exactly OP_W clocks, closing edge of CS
  assign sleep_req_o = cs_rise_i && frame_q && cnt_q == CNT_FULL && sr_q == SLEEP_OP;

  a_r3_opv_not_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |-> op_o != SLEEP_OP);
  a_r3_opv_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |=> !op_valid_o);
  a_r6_clear_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise_i |=> cnt_q == '0 && !frame_q);
  a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_OVER);
endmodule

// File: rtl/spi_pwr_fsm.sv
module spi_pwr_fsm
  import spi_sleep_pkg::*;
#(
  parameter int REC_CYCLES = 40000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_req_i,
  input  logic cs_fall_i,
  output logic asleep_o,
  output logic ready_o,
  output logic viol_o
);
  localparam int REC_W = $clog2(REC_CYCLES + 1);
  localparam logic [REC_W-1:0] REC_LAST = REC_W'(REC_CYCLES - 1);

  pwr_state_e       state_q;
  logic [REC_W-1:0] rec_cnt_q;
  logic             viol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= PWR_AWAKE;
      rec_cnt_q <= '0;
      viol_q    <= 1'b0;
    end else begin
      unique case (state_q)
        PWR_AWAKE:  if (sleep_req_i) state_q <= PWR_ASLEEP;
        PWR_ASLEEP: if (cs_fall_i) begin
          state_q   <= PWR_RECOVER;
          rec_cnt_q <= '0;
        end
        PWR_RECOVER: begin
          if (cs_fall_i) viol_q <= 1'b1;
          if (rec_cnt_q == REC_LAST) state_q <= PWR_AWAKE;
          else rec_cnt_q <= rec_cnt_q + 1'b1;
        end
        default: state_q <= PWR_AWAKE;
      endcase
    end
  end

  assign asleep_o = state_q == PWR_ASLEEP;
  assign ready_o  = state_q == PWR_AWAKE;
  assign viol_o   = viol_q;

  a_r4_sleep_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(asleep_o) |-> $past(sleep_req_i));
  a_r8_wake_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(asleep_o) |-> $past(cs_fall_i) && !ready_o);
  a_r8_full_lockout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ready_o) && !$past(asleep_o)) |-> $past(rec_cnt_q) == REC_LAST);
  a_r10_viol_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |=> viol_o);
endmodule

// File: rtl/spi_sleep_ctrl.sv
module spi_sleep_ctrl #(
  parameter int OP_W       = 8,
  parameter int REC_CYCLES = 40000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cs_ni,
  input  logic            sck_i,
  input  logic            si_i,
  input  logic            so_data_i,
  output logic            so_o,
  output logic            so_oe_o,
  output logic [OP_W-1:0] op_o,
  output logic            op_valid_o,
  output logic            asleep_o,
  output logic            ready_o,
  output logic            viol_o
);
  logic [2:0] lvl;
  logic       cs_s, sck_s, si_s, cs_d, sck_d;
  logic       cs_fall, cs_rise, sck_rise;
  logic       frame_ok, sleep_req;

  // order {cs, sck, si}; CS idles high
  spi_in_sync #(.N(3), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sck_i, si_i}),
    .lvl_o (lvl)
  );
  assign {cs_s, sck_s, si_s} = lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      cs_d  <= cs_s;
      sck_d <= sck_s;
    end
  end

  assign cs_fall  = cs_d && !cs_s;
  assign cs_rise  = !cs_d && cs_s;
  assign sck_rise = !sck_d && sck_s;

  spi_op_shifter #(.OP_W(OP_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (ready_o),
    .cs_lvl_i   (cs_s),
    .cs_fall_i  (cs_fall),
    .cs_rise_i  (cs_rise),
    .sck_rise_i (sck_rise),
    .si_i       (si_s),
    .frame_ok_o (frame_ok),
    .op_o       (op_o),
    .op_valid_o (op_valid_o),
    .sleep_req_o(sleep_req)
  );

  spi_pwr_fsm #(.REC_CYCLES(REC_CYCLES)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sleep_req_i(sleep_req),
    .cs_fall_i  (cs_fall),
    .asleep_o   (asleep_o),
    .ready_o    (ready_o),
    .viol_o     (viol_o)
  );

  assign so_oe_o = ready_o && frame_ok && !cs_s;
  assign so_o    = so_oe_o && so_data_i;

  a_r7_quiet_asleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asleep_o |-> !so_oe_o && !op_valid_o);
  a_r11_oe_awake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_oe_o |-> ready_o && !cs_s);
  a_r4_sleep_on_cs_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(asleep_o) |-> $past(cs_rise));
endmodule

// File: tb/spi_sleep_ctrl_tb.sv
module spi_sleep_ctrl_tb_top;
  localparam int REC = 200;
  localparam int H   = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, so_data = 1'b0;
  logic so, so_oe, opv, asleep, ready, viol;
  logic [7:0] op;

  int vectors = 0, miscompares = 0;
  int opv_cnt = 0;
  logic [7:0] last_op = '0;

  always #2.5 clk = ~clk;

  spi_sleep_ctrl #(.OP_W(8), .REC_CYCLES(REC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si),
    .so_data_i(so_data), .so_o(so), .so_oe_o(so_oe), .op_o(op),
    .op_valid_o(opv), .asleep_o(asleep), .ready_o(ready), .viol_o(viol)
  );

  always @(negedge clk) if (opv) begin
    opv_cnt = opv_cnt + 1;
    last_op = op;
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] b, input int nbits, input bit m3);
    sck = m3;
    cyc(4);
    cs_n = 1'b0;
    cyc(H);
    for (int i = 0; i < nbits; i++) begin
      if (m3) begin
        sck = 1'b0; si = (i < 8) ? b[7-i] : 1'b0; cyc(H);
        sck = 1'b1; cyc(H);
      end else begin
        si = (i < 8) ? b[7-i] : 1'b0; cyc(H);
        sck = 1'b1; cyc(H);
        sck = 1'b0;
      end
    end
    cyc(H);
    cs_n = 1'b1;
    cyc(8);
  endtask

  task automatic wake();
    cs_n = 1'b0;
    cyc(REC + 6);
    cs_n = 1'b1;
    cyc(8);
  endtask

  task automatic go_sleep();
    frame(8'hB9, 8, 1'b0);
    chk("R4 enter", asleep, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int base;
    cyc(3);
    // R1 reset state
    chk("R1 asleep", asleep, 0);
    chk("R1 ready", ready, 1);
    chk("R1 viol", viol, 0);
    chk("R1 opv", opv, 0);
    chk("R1 oe", so_oe, 0);
    rst_n = 1'b1;
    cyc(4);

    // R2 R3 R4 sweep of every opcode, both clock idle levels
    for (int v = 0; v < 256; v++) begin
      base = opv_cnt;
      frame(8'(v), 8, v[0]);
      chk("R3 opv count", opv_cnt - base, (v != 8'hB9) ? 1 : 0);
      if (v != 8'hB9) chk("R2 opcode", int'(last_op), v);
      chk("R4 asleep", asleep, (v == 8'hB9) ? 1 : 0);
      if (asleep) wake();
      chk("R3 ready", ready, 1);
    end

    // R5 extra clocks cancel
    for (int x = 9; x <= 12; x++) begin
      frame(8'hB9, x, x[0]);
      chk("R5 cancel", asleep, 0);
      chk("R5 ready", ready, 1);
    end

    // R6 partial frames
    for (int n = 1; n < 8; n++) begin
      base = opv_cnt;
      frame(8'hB9, n, 1'b0);
      chk("R6 partial no sleep", asleep, 0);
      chk("R6 partial no opv", opv_cnt - base, 0);
    end
    frame(8'h03, 8, 1'b1);
    chk("R6 clean next", int'(last_op), 3);
    frame(8'hB9, 5, 1'b0);
    frame(8'hB9, 8, 1'b1);
    chk("R6 sleep after partial", asleep, 1);

    // R7 ignored inputs while asleep
    base = opv_cnt;
    for (int k = 0; k < 20; k++) begin
      sck = ~sck; si = ~si; cyc(3);
    end
    sck = 1'b0;
    cyc(6);
    chk("R7 stays asleep", asleep, 1);
    chk("R7 no opv", opv_cnt - base, 0);
    chk("R7 oe", so_oe, 0);

    // R8 lockout timing, bits during lockout ignored
    so_data = 1'b1;
    cs_n = 1'b0;
    cyc(5);
    chk("R8 asleep cleared", asleep, 0);
    chk("R8 not ready", ready, 0);
    for (int i = 0; i < 8; i++) begin
      si = 1'b1; cyc(H); sck = 1'b1; cyc(H); sck = 1'b0;
    end
    chk("R8 oe in lockout", so_oe, 0);
    chk("R8 so in lockout", so, 0);
    cyc(REC - 5 - 8 * 2 * H);
    chk("R8 not ready at REC", ready, 0);
    cyc(4);
    chk("R8 ready after REC", ready, 1);
    chk("R8 lockout bits ignored", opv_cnt - base, 0);
    cs_n = 1'b1;
    cyc(8);
    so_data = 1'b0;

    // R9 early deselect
    go_sleep();
    cs_n = 1'b0; cyc(10);
    cs_n = 1'b1; cyc(REC - 10);
    chk("R9 not ready early", ready, 0);
    cyc(4);
    chk("R9 ready", ready, 1);
    chk("R9 no viol", viol, 0);

    // R10 reselect during lockout
    go_sleep();
    base = opv_cnt;
    cs_n = 1'b0; cyc(10);
    cs_n = 1'b1; cyc(10);
    cs_n = 1'b0;
    for (int i = 0; i < 8; i++) begin
      si = ~si; cyc(H); sck = 1'b1; cyc(H); sck = 1'b0;
    end
    cyc(4);
    chk("R10 viol set", viol, 1);
    chk("R10 not decoded", opv_cnt - base, 0);
    cs_n = 1'b1;
    cyc(REC);
    chk("R10 ready later", ready, 1);
    frame(8'h05, 8, 1'b0);
    chk("R10 decode resumes", int'(last_op), 5);
    chk("R10 viol sticky", viol, 1);
    rst_n = 1'b0; cyc(2);
    chk("R10 viol reset", viol, 0);
    rst_n = 1'b1; cyc(4);

    // R11 output enable
    cs_n = 1'b0; so_data = 1'b1; cyc(6);
    chk("R11 oe", so_oe, 1);
    chk("R11 so high", so, 1);
    so_data = 1'b0; cyc(1);
    chk("R11 so low", so, 0);
    cs_n = 1'b1; so_data = 1'b1; cyc(6);
    chk("R11 oe off", so_oe, 0);
    chk("R11 so gated", so, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule